// File: doc/BRIEF.md
# Serial Memory Slave Front End with Hold and Quad Read

This block is the slave side of a byte-wide serial nonvolatile memory. A host selects it with an active-low chip select and clocks it with a serial clock. The host sends an 8-bit command, then a 24-bit address where the command needs one, then write data. The block returns read data or its status byte. All four serial lanes come in as separate in/out/enable ports, and the pad tri-state buffers sit outside the block. Lane 0 is the serial data input, lane 1 the serial data output, lane 2 the active-low write-protect input and lane 3 the active-low hold input. A quad read command turns all four lanes into outputs for its data phase.

The serial pins are sampled by the system clock through two-flop synchronizers, and the serial clock edges are found in that domain. The serial clock must therefore run well below the system clock: at least six system clocks per serial half period. The array is a synchronous RAM of 2^ARRAY_AW bytes. The full-size part uses ARRAY_AW = 19 (512K bytes); the default is smaller so that elaboration stays light. The address is taken from the low ARRAY_AW bits of the 24 bits received.

The states and their transitions are:
- ST_IDLE goes to ST_CMD when chip select is seen low.
- ST_CMD decodes the 8th command bit:
  - 0x06 and 0x04 go to ST_SINK.
  - 0x05 goes to ST_SRREAD.
  - 0x01 goes to ST_SRWRITE if the write latch is set, and to ST_SINK otherwise.
  - 0x03 and 0x6B go to ST_ADDR.
  - 0x02 goes to ST_ADDR if the latch is set, and to ST_SINK otherwise.
  - Unknown codes go to ST_SINK.
- ST_ADDR goes, after 24 bits, to ST_DUMMY for a quad read, to ST_WRITE for a write, and to ST_READ otherwise.
- ST_DUMMY goes to ST_QREAD after 8 serial clocks.
- ST_SRWRITE goes to ST_SINK after 8 bits.
- ST_READ, ST_QREAD, ST_WRITE, ST_SRREAD and ST_SINK stay where they are.
- Every state returns to ST_IDLE when chip select is seen high.

Top module: `sfm_slave`

## Requirements
- R1: While chip select is high, io_oe is 0 on all lanes, and serial clock activity changes no state (clocking a 0x06 command while deselected leaves status bit 1 at 0).
- R2: A transfer starts at the chip-select falling edge. Bits are taken MSB first on serial clock rising edges. Output bits change only after serial clock falling edges, and the first output bit follows the falling edge that ends the last input bit.
- R3: The status byte has the write-enable latch in bit 1, WPEN in bit 7 and 0 elsewhere, and reads 0x00 after reset. Command 0x05 returns it repeatedly. 0x06 sets the latch and 0x04 clears it.
- R4: Outside quad read, io_in[3] low with chip select low suspends the transfer. Lane 1 is undriven and serial clock and data are ignored. Shifting resumes at the same bit when io_in[3] returns high.
- R5: Command 0x01 writes bit 7 of its data byte into WPEN. It has no effect when io_in[2] is low and WPEN is 1.
- R6: Command 0x6B takes a 24-bit address and then 8 dummy clocks. It then returns each byte as two nibbles, high nibble first, on io_out[3:0]. All four lanes are enabled only in the data phase, and io_in[2] and io_in[3] have no effect during the command.
- R7: Command 0x03 takes a 24-bit address, MSB first, of which only the low ARRAY_AW bits are used. It returns bytes on lane 1 MSB first and increments the address after each byte.
- R8: Command 0x02 writes successive bytes to successive addresses only when the latch is set, and is ignored otherwise. The latch is cleared by the chip-select rise that ends an accepted 0x02 or 0x01.
- R9: Incrementing past the top address wraps to 0 within one transfer, for reads and writes.
- R10: A write byte cut short by chip select going high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| io_in | input | 4 | Lane inputs: 0 data in, 2 write-protect (low active), 3 hold (low active) |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |

## Verification
The assertions assume the following about the inputs:
- The serial clock and chip select change slowly compared with the system clock, so that every edge is seen after synchronization.
- The hold input changes only while the serial clock is low.
- The write-protect level is steady across a status write.

The bench holds every serial half period at eight system clocks and waits four clocks around hold changes and chip-select edges. The random part varies only addresses (including the ignored upper bits), data and burst lengths.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_READ,
        ST_QREAD, ST_WRITE, ST_SRREAD, ST_SRWRITE, ST_SINK
    } state_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_QREAD = 8'h6B;
endpackage

// File: rtl/sfm_sync.sv
module sfm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= rst_val;
            q    <= rst_val;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sfm_ram.sv
module sfm_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rq
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        rq <= mem[ra];
    end
endmodule

// File: rtl/sfm_slave.sv
module sfm_slave
    import sfm_pkg::*;
#(
    parameter int ARRAY_AW   = 10,
    parameter int ADDR_BYTES = 3,
    parameter int DUMMY_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic [3:0] io_in,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);
    localparam int ADDR_BITS = 8 * ADDR_BYTES;
    localparam int CNT_W     = $clog2(ADDR_BITS + DUMMY_CLKS) + 1;

    state_t state, nxt;

    logic              cs_s, sck_s, sck_d;
    logic [3:0]        io_s;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        sreg, tx, cmd_byte, stat;
    logic [2:0]        txcnt;
    logic [3:0]        dq, lo_nib;
    logic [ARRAY_AW-1:0] addr;
    logic              wel, wpen, is_quad, wr_op, end_clr, drv, nib;
    logic              hold_act, rise, fall, ram_we;
    logic [7:0]        ram_q;

    sfm_sync #(.W(6)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sck, io_in}), .rst_val(6'b101111),
        .q({cs_s, sck_s, io_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign hold_act = ~cs_s & ~io_s[3] & ~is_quad;
    assign rise     = sck_s & ~sck_d & ~hold_act;
    assign fall     = ~sck_s & sck_d & ~hold_act;
    assign cmd_byte = {sreg[6:0], io_s[0]};
    assign stat     = {wpen, 5'b0, wel, 1'b0};
    assign ram_we   = (state == ST_WRITE) && rise && (cnt == CNT_W'(7));

    sfm_ram #(.AW(ARRAY_AW), .DW(8)) u_ram (
        .clk(clk), .we(ram_we), .wa(addr), .wd(cmd_byte),
        .ra(addr), .rq(ram_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!cs_s) nxt = ST_CMD;
            ST_CMD: if (rise && cnt == CNT_W'(7)) begin
                unique case (cmd_byte)
                    OP_RDSR:            nxt = ST_SRREAD;
                    OP_WRSR:            nxt = wel ? ST_SRWRITE : ST_SINK;
                    OP_READ, OP_QREAD:  nxt = ST_ADDR;
                    OP_WRITE:           nxt = wel ? ST_ADDR : ST_SINK;
                    default:            nxt = ST_SINK;
                endcase
            end
            ST_ADDR: if (rise && cnt == CNT_W'(ADDR_BITS - 1))
                nxt = is_quad ? ST_DUMMY : (wr_op ? ST_WRITE : ST_READ);
            ST_DUMMY: if (rise && cnt == CNT_W'(DUMMY_CLKS - 1)) nxt = ST_QREAD;
            ST_SRWRITE: if (rise && cnt == CNT_W'(7)) nxt = ST_SINK;
            ST_READ, ST_QREAD, ST_WRITE, ST_SRREAD, ST_SINK: nxt = state;
            default: nxt = ST_IDLE;
        endcase
        if (cs_s) nxt = ST_IDLE;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; sreg <= '0; tx <= '0; txcnt <= '0; dq <= '0;
            lo_nib <= '0; addr <= '0; wel <= 1'b0; wpen <= 1'b0;
            is_quad <= 1'b0; wr_op <= 1'b0; end_clr <= 1'b0;
            drv <= 1'b0; nib <= 1'b0;
        end else if (cs_s) begin
            if (end_clr) wel <= 1'b0;
            end_clr <= 1'b0; is_quad <= 1'b0; wr_op <= 1'b0;
            drv <= 1'b0; nib <= 1'b0; txcnt <= '0; cnt <= '0;
        end else begin
            if (state != nxt) cnt <= '0;
            else if (rise) cnt <= (state == ST_WRITE && cnt == CNT_W'(7)) ? '0 : cnt + 1'b1;
            if (rise) begin
                sreg <= cmd_byte;
                if (state == ST_ADDR) addr <= {addr[ARRAY_AW-2:0], io_s[0]};
                if (ram_we) addr <= addr + 1'b1;
                if (state == ST_CMD && cnt == CNT_W'(7)) begin
                    if (cmd_byte == OP_WREN) wel <= 1'b1;
                    if (cmd_byte == OP_WRDI) wel <= 1'b0;
                    is_quad <= (cmd_byte == OP_QREAD);
                    wr_op   <= (cmd_byte == OP_WRITE);
                    end_clr <= wel && (cmd_byte == OP_WRITE || cmd_byte == OP_WRSR);
                end
                if (state == ST_SRWRITE && cnt == CNT_W'(7) && !(wpen && !io_s[2]))
                    wpen <= cmd_byte[7];
            end
            if (fall && (state == ST_READ || state == ST_SRREAD)) begin
                drv <= 1'b1;
                if (txcnt == 3'd0) begin
                    dq    <= {2'b00, (state == ST_READ) ? ram_q[7] : stat[7], 1'b0};
                    tx    <= (state == ST_READ) ? {ram_q[6:0], 1'b0} : {stat[6:0], 1'b0};
                    txcnt <= 3'd7;
                    if (state == ST_READ) addr <= addr + 1'b1;
                end else begin
                    dq    <= {2'b00, tx[7], 1'b0};
                    tx    <= {tx[6:0], 1'b0};
                    txcnt <= txcnt - 1'b1;
                end
            end
            if (fall && state == ST_QREAD) begin
                drv <= 1'b1;
                nib <= ~nib;
                if (!nib) begin
                    dq     <= ram_q[7:4];
                    lo_nib <= ram_q[3:0];
                    addr   <= addr + 1'b1;
                end else begin
                    dq <= lo_nib;
                end
            end
        end
    end

    // lane outputs
    always_comb begin
        io_out = dq;
        if (state == ST_QREAD && drv) io_oe = 4'hF;
        else io_oe = {2'b00, drv & ~hold_act & (state == ST_READ || state == ST_SRREAD), 1'b0};
    end

    // R1: deselect releases every lane by the next cycle
    p_standby_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (io_oe == 4'b0000));

    // R4: suspension freezes the sequencer and the bit position
    p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |=> ($stable(state) && $stable(cnt)));

    // R5: locked status register keeps WPEN
    p_sr_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SRWRITE && wpen && !io_s[2]) |=> wpen);

    // R6: the upper lanes are only driven for a quad command
    p_quad_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe[3] |-> is_quad);

    // R8: array writes need the write latch
    p_wel_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wel);

    // R9: address steps by one and wraps after each stored byte
    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (addr == $past(addr) + 1'b1));
endmodule

// File: tb/sfm_slave_test.sv
module sfm_slave_test;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic [3:0] io_in = 4'b1111;
    logic [3:0] io_out, io_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    logic       m_wel = 1'b0, m_wpen = 1'b0;

    sfm_slave #(.ARRAY_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_status(input logic wp_en, input logic we_l);
        return {wp_en, 5'b0, we_l, 1'b0};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        io_in[0] = b;
        tick(2);
        sck = 1'b1;
        tick(8);
        sck = 1'b0;
        tick(6);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            v[i] = io_out[1];
            pulse(1'b0);
        end
    endtask

    task automatic recv_quad(output logic [7:0] v);
        v[7:4] = io_out;
        pulse(1'b0);
        v[3:0] = io_out;
        pulse(1'b0);
    endtask

    task automatic sel;
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel;
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic simple_cmd(input logic [7:0] op);
        sel; send_byte(op); desel;
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] v);
        sel; send_byte(8'h05); recv_byte(v); desel;
    endtask

    task automatic write_burst(input logic [23:0] a, input int n, input logic [7:0] d [4]);
        sel; send_byte(8'h02);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i]);
            if (m_wel) begin
                model[(a + i) % DEPTH] = d[i];
                known[(a + i) % DEPTH] = 1'b1;
            end
        end
        desel;
        m_wel = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [23:0] a, input int n);
        logic [7:0] v;
        sel; send_byte(8'h03);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
        for (int i = 0; i < n; i++) begin
            recv_byte(v);
            if (known[(a + i) % DEPTH]) chk(tag, v, model[(a + i) % DEPTH]);
        end
        desel;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d [4];
        logic [23:0] a;
        int n;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset and standby state
        chk("R1 oe after reset", io_oe, 4'h0);
        read_status(v);
        chk("R3 status after reset", v, exp_status(1'b0, 1'b0));

        // R1: clocking while deselected is ignored
        send_byte(8'h06);
        chk("R1 oe while deselected", io_oe, 4'h0);
        read_status(v);
        chk("R1 status after deselected clocks", v, exp_status(1'b0, 1'b0));

        // R3: latch set and cleared
        simple_cmd(8'h06);
        read_status(v);
        chk("R3 latch set", v, exp_status(m_wpen, m_wel));
        simple_cmd(8'h04);
        read_status(v);
        chk("R3 latch cleared", v, exp_status(m_wpen, m_wel));

        // R2/R7: status repeats, first bit after opcode
        sel; send_byte(8'h06); desel; m_wel = 1'b1;
        sel; send_byte(8'h05);
        chk("R2 lane1 enabled after opcode", io_oe, 4'h2);
        recv_byte(v); chk("R3 status first", v, 8'h02);
        recv_byte(v); chk("R3 status repeated", v, 8'h02);
        desel;

        // R8: write with latch, latch cleared afterwards
        d = '{8'hA5, 8'h3C, 8'h00, 8'h00};
        write_burst(24'h000010, 2, d);
        read_status(v);
        chk("R8 latch cleared by write end", v, exp_status(m_wpen, 1'b0));
        read_check("R8 written data", 24'h000010, 2);

        // R8: write without latch ignored
        d = '{8'h11, 8'h22, 8'h00, 8'h00};
        write_burst(24'h000010, 2, d);
        read_check("R8 write without latch ignored", 24'h000010, 2);

        // R9: wrap on write and read
        simple_cmd(8'h06);
        d = '{8'hDE, 8'hAD, 8'h00, 8'h00};
        write_burst(24'h0003FF, 2, d);
        read_check("R9 wrap", 24'h0003FF, 2);

        // R10: partial byte discarded
        simple_cmd(8'h06);
        sel; send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); send_byte(8'h10);
        send_byte(8'h77);
        model[16] = 8'h77;
        for (int i = 0; i < 5; i++) pulse(1'b1);
        desel; m_wel = 1'b0;
        read_check("R10 partial byte", 24'h000010, 2);

        // R4: hold in the middle of a write byte
        simple_cmd(8'h06);
        sel; send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); send_byte(8'h20);
        pulse(1'b1); pulse(1'b0); pulse(1'b0); pulse(1'b1);
        io_in[3] = 1'b0; tick(4);
        pulse(1'b1); pulse(1'b1); pulse(1'b0);
        io_in[3] = 1'b1; tick(4);
        pulse(1'b0); pulse(1'b1); pulse(1'b1); pulse(1'b0);
        desel; m_wel = 1'b0;
        model[32] = 8'h96; known[32] = 1'b1;
        read_check("R4 hold during write", 24'h000020, 1);

        // R4: hold during read releases lane 1 and resumes
        sel; send_byte(8'h03); send_byte(8'h00); send_byte(8'h00); send_byte(8'h20);
        for (int i = 7; i >= 4; i--) begin v[i] = io_out[1]; pulse(1'b0); end
        io_in[3] = 1'b0; tick(4);
        chk("R4 lane1 released in hold", io_oe, 4'h0);
        pulse(1'b0); pulse(1'b0);
        io_in[3] = 1'b1; tick(4);
        chk("R4 lane1 back after hold", io_oe, 4'h2);
        for (int i = 3; i >= 0; i--) begin v[i] = io_out[1]; pulse(1'b0); end
        desel;
        chk("R4 read across hold", v, 8'h96);

        // R5: status write allowed, then locked by pin
        simple_cmd(8'h06);
        sel; send_byte(8'h01); send_byte(8'h80); desel;
        m_wpen = 1'b1; m_wel = 1'b0;
        read_status(v);
        chk("R5 WPEN set", v, exp_status(1'b1, 1'b0));
        simple_cmd(8'h06);
        io_in[2] = 1'b0; tick(4);
        sel; send_byte(8'h01); send_byte(8'h00); desel;
        m_wel = 1'b0;
        io_in[2] = 1'b1; tick(4);
        read_status(v);
        chk("R5 locked status write blocked", v, exp_status(1'b1, 1'b0));
        simple_cmd(8'h06);
        sel; send_byte(8'h01); send_byte(8'h00); desel;
        m_wpen = 1'b0; m_wel = 1'b0;
        read_status(v);
        chk("R5 unlocked status write", v, exp_status(1'b0, 1'b0));

        // R6: quad read with pins low, lanes only in data phase
        simple_cmd(8'h06);
        d = '{8'h5A, 8'hC3, 8'h0F, 8'hE1};
        write_burst(24'h000040, 4, d);
        sel; send_byte(8'h6B);
        io_in[3] = 1'b0; io_in[2] = 1'b0;
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h40);
        chk("R6 lanes off before dummy", io_oe, 4'h0);
        for (int i = 0; i < 7; i++) pulse(1'b0);
        chk("R6 lanes off in dummy", io_oe, 4'h0);
        pulse(1'b0);
        chk("R6 lanes on in data", io_oe, 4'hF);
        for (int i = 0; i < 4; i++) begin
            recv_quad(v);
            chk("R6 quad data", v, model[64 + i]);
        end
        desel;
        io_in[3] = 1'b1; io_in[2] = 1'b1; tick(4);
        chk("R1 quad lanes off after deselect", io_oe, 4'h0);

        // R7/R8: random bursts with random upper address bits
        for (int it = 0; it < 16; it++) begin
            a = {$urandom_range(255, 0), 16'h0} | 24'($urandom_range(DEPTH - 1, 0));
            n = $urandom_range(4, 1);
            for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
            simple_cmd(8'h06);
            write_burst(a, n, d);
            read_check("R7 random burst", a ^ 24'h550000, n);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule